// File: doc/BRIEF.md
# Voice Word Output Sequencer with Tone Insertion

This block sits after the line demodulator of a subscriber-side loop transceiver. Each time the demodulator finishes a frame from the master, it strobes `frm_done` with the recovered 8-bit voice word and two signaling bits. The sequencer then opens a transmit window toward the codec. During the window it drives a gated serial clock burst and shifts the word out MSB first. The signaling outputs are refreshed in the same cycle the window opens.

With `tone_en` high, the voice word is replaced by a square wave made of two fixed PCM codes. The code toggles every `TONE_FRAMES` frame ticks, which gives a keypress feedback tone. The tone also needs windows when the master is silent. Once `MISS_TICKS` frame ticks have passed with no burst, every frame tick opens a window by itself.

In loopback the windows still open, but the serial clock stays low, so the codec loads nothing and no tone can sound.

Top module: `voice_out_seq`

## Requirements
- R1: A `frm_done` pulse seen while idle raises `xmt_en` in the following cycle. `xmt_en` then stays high for exactly `2*WORD_W*CLK_DIV` cycles and falls back low.
- R2: Each window carries exactly `WORD_W` rising edges of `ser_clk`. Each clock period is `CLK_DIV` cycles low followed by `CLK_DIV` cycles high. `ser_clk` is low whenever `xmt_en` is low.
- R3: The word leaves on `ser_dat` MSB first, one bit per `ser_clk` period. Each bit is stable for the whole high phase of its clock.
- R4: `sig_out` takes `frm_sig` (bit 1 to bit 1, bit 0 to bit 0) in the cycle `xmt_en` rises for a burst. At all other times it holds.
- R5: A `frm_done` pulse that arrives while a window is open is ignored. The running word, the window length and `sig_out` are unaffected, and no extra window follows.
- R6: If `tone_en` is high when a window starts, the word sent is `TONE_POS` (default 8'h9A) in tone phase 0 and `TONE_NEG` (default 8'h1A) in phase 1. The phase is 0 after reset and toggles after every `TONE_FRAMES` (default 8) `tick_125` pulses.
- R7: When `tone_en` is high and at least `MISS_TICKS` (default 2) ticks have passed since the last `frm_done`, each `tick_125` pulse seen while idle opens a tone window. In such a window `sig_out` keeps its old value.
- R8: With `tone_en` low, frame ticks never open a window.
- R9: While `loop_en` is high, `ser_clk` is held low. Windows and `sig_out` updates still happen.
- R10: After reset, `xmt_en`, `ser_clk` and `sig_out` are 0, the tone phase is 0 and no ticks are counted as missed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a demodulated frame is ready |
| frm_word | input | WORD_W | Demodulated voice word |
| frm_sig | input | 2 | Demodulated signaling bits |
| tone_en | input | 1 | Replace voice with the square-wave tone |
| loop_en | input | 1 | Loopback: hold the serial clock low |
| tick_125 | input | 1 | One-cycle frame tick from the internal timebase |
| xmt_en | output | 1 | Transmit window toward the codec |
| ser_clk | output | 1 | Gated serial clock burst |
| ser_dat | output | 1 | Serial word, MSB first |
| sig_out | output | 2 | Latched signaling bits |

## Verification
Several internal faults show up at the ports within one window.

- A wrong half-period or bit counter makes the window length or the pulse count wrong at the next falling `xmt_en`.
- A broken shifter corrupts the word assembled from the `ser_clk` rising edges of that same window.
- A bad tone phase counter shows only at a phase boundary, so the bench sends more than two full `TONE_FRAMES` of ticks.
- A bad miss counter shows as a self-started window arriving one tick too early or too late, or arriving with `tone_en` low. The scoreboard reports that window as unexpected or missing.

// File: rtl/voice_out_pkg.sv
package voice_out_pkg;

  typedef enum logic {PH_POS = 1'b0, PH_NEG = 1'b1} tone_ph_e;

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tone_gen.sv
module tone_gen
  import voice_out_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int TONE_FRAMES = 8,
  parameter logic [WORD_W-1:0] TONE_POS = 8'h9A,
  parameter logic [WORD_W-1:0] TONE_NEG = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [WORD_W-1:0] tone_word
);
  localparam int TW = cnt_w(TONE_FRAMES);

  logic [TW-1:0] tcnt;
  tone_ph_e      phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt  <= '0;
      phase <= PH_POS;
    end else if (tick) begin
      if (tcnt == TW'(TONE_FRAMES - 1)) begin
        tcnt  <= '0;
        phase <= (phase == PH_POS) ? PH_NEG : PH_POS;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign tone_word = (phase == PH_POS) ? TONE_POS : TONE_NEG;
endmodule

// File: rtl/frame_watch.sv
module frame_watch
  import voice_out_pkg::*;
#(
  parameter int MISS_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic done,
  output logic starved
);
  localparam int MW = cnt_w(MISS_TICKS + 1);

  logic [MW-1:0] miss;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      miss <= '0;
    end else if (tick && miss != MW'(MISS_TICKS)) begin
      miss <= miss + 1'b1;
    end
  end

  assign starved = (miss == MW'(MISS_TICKS));
endmodule

// File: rtl/ser_window.sv
module ser_window
  import voice_out_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] load_word,
  input  logic              loop_en,
  output logic              busy,
  output logic              sclk,
  output logic              sdat
);
  localparam int HALVES = 2 * WORD_W;
  localparam int DW = cnt_w(CLK_DIV);
  localparam int HW = cnt_w(HALVES);

  logic [DW-1:0]     div;
  logic [HW-1:0]     half;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      div  <= '0;
      half <= '0;
      sh   <= '0;
    end else begin
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= load_word;
          div  <= '0;
          half <= '0;
          sclk <= 1'b0;
        end
      end else if (div == DW'(CLK_DIV - 1)) begin
        div <= '0;
        if (half == HW'(HALVES - 1)) begin
          busy <= 1'b0;
          sclk <= 1'b0;
          half <= '0;
        end else begin
          half <= half + 1'b1;
          if (!half[0]) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            sh   <= {sh[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
      if (loop_en) sclk <= 1'b0;
    end
  end

  assign sdat = sh[WORD_W-1];
endmodule

// File: rtl/voice_out_seq.sv
module voice_out_seq
  import voice_out_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CLK_DIV = 2,
  parameter int TONE_FRAMES = 8,
  parameter int MISS_TICKS = 2,
  parameter logic [WORD_W-1:0] TONE_POS = 8'h9A,
  parameter logic [WORD_W-1:0] TONE_NEG = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_done,
  input  logic [WORD_W-1:0] frm_word,
  input  logic [1:0]        frm_sig,
  input  logic              tone_en,
  input  logic              loop_en,
  input  logic              tick_125,
  output logic              xmt_en,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic [1:0]        sig_out
);
  logic [WORD_W-1:0] tone_word;
  logic [WORD_W-1:0] word_sel;
  logic              starved;
  logic              self_go;
  logic              go;

  tone_gen #(
    .WORD_W(WORD_W), .TONE_FRAMES(TONE_FRAMES),
    .TONE_POS(TONE_POS), .TONE_NEG(TONE_NEG)
  ) tone_i (
    .clk(clk), .rst(rst), .tick(tick_125), .tone_word(tone_word)
  );

  frame_watch #(.MISS_TICKS(MISS_TICKS)) watch_i (
    .clk(clk), .rst(rst), .tick(tick_125), .done(frm_done), .starved(starved)
  );

  assign self_go  = tick_125 & tone_en & starved;
  assign go       = (frm_done | self_go) & ~xmt_en;
  assign word_sel = tone_en ? tone_word : frm_word;

  ser_window #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) win_i (
    .clk(clk), .rst(rst), .start(go), .load_word(word_sel),
    .loop_en(loop_en), .busy(xmt_en), .sclk(ser_clk), .sdat(ser_dat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_out <= 2'b00;
    end else if (frm_done && !xmt_en) begin
      sig_out <= frm_sig;
    end
  end
endmodule

// File: rtl/voice_out_seq_chk.sv
module voice_out_seq_chk #(
  parameter int WORD_W = 8,
  parameter int CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       loop_en,
  input logic       xmt_en,
  input logic       ser_clk,
  input logic       ser_dat,
  input logic [1:0] sig_out
);
  int   hi_cnt;
  int   rise_cnt;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= 0;
      rise_cnt <= 0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= ser_clk;
      hi_cnt <= xmt_en ? hi_cnt + 1 : 0;
      if (!xmt_en) rise_cnt <= 0;
      else if (ser_clk && !sclk_d) rise_cnt <= rise_cnt + 1;
    end
  end

  a_r1_window_len: assert property (@(posedge clk) disable iff (rst)
    $fell(xmt_en) |-> hi_cnt == 2 * WORD_W * CLK_DIV);

  a_r2_clk_in_window: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> xmt_en);

  a_r2_pulse_cap: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= WORD_W);

  a_r3_data_steady: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_dat));

  a_r4_sig_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(xmt_en) |-> $stable(sig_out));

  a_r9_loop_low: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> !ser_clk);
endmodule

bind voice_out_seq voice_out_seq_chk #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rst(rst), .loop_en(loop_en), .xmt_en(xmt_en),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .sig_out(sig_out)
);

// File: tb/voice_out_seq_tb_top.sv
`timescale 1ns/1ps
module voice_out_seq_tb_top;
  localparam int WORD_W = 8;
  localparam int CLK_DIV = 2;
  localparam int TONE_FRAMES = 8;
  localparam int MISS_TICKS = 2;
  localparam logic [7:0] TPOS = 8'h9A;
  localparam logic [7:0] TNEG = 8'h1A;
  localparam int WIN_LEN = 2 * WORD_W * CLK_DIV;
  localparam int GAP = WIN_LEN + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_done = 1'b0;
  logic [7:0] frm_word = '0;
  logic [1:0] frm_sig = '0;
  logic tone_en = 1'b0;
  logic loop_en = 1'b0;
  logic tick_125 = 1'b0;
  logic xmt_en, ser_clk, ser_dat;
  logic [1:0] sig_out;

  always #2.5 clk = ~clk;

  voice_out_seq #(
    .WORD_W(WORD_W), .CLK_DIV(CLK_DIV), .TONE_FRAMES(TONE_FRAMES),
    .MISS_TICKS(MISS_TICKS), .TONE_POS(TPOS), .TONE_NEG(TNEG)
  ) dut_i (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_word(frm_word),
    .frm_sig(frm_sig), .tone_en(tone_en), .loop_en(loop_en),
    .tick_125(tick_125), .xmt_en(xmt_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .sig_out(sig_out)
  );

  typedef struct {
    logic [7:0] word;
    logic [1:0] sig;
    logic       loop;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int ticks_total = 0;
  int ticks_since_done = 0;
  int win_exp = 0;
  int win_seen = 0;
  logic [1:0] last_sig = 2'b00;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] tone_now();
    return (((ticks_total / TONE_FRAMES) % 2) == 0) ? TPOS : TNEG;
  endfunction

  // monitor: pops expected windows and compares what the ports show
  exp_t cur;
  logic prev_xe = 1'b0;
  logic prev_sc = 1'b0;
  int width, pulses;
  logic [7:0] bits;

  always @(negedge clk) begin
    if (!rst) begin
      if (xmt_en && !prev_xe) begin
        win_seen++;
        width = 0; pulses = 0; bits = '0;
        if (q.size() == 0) begin
          chk(0, "R8 unexpected window", 1, 0);
          cur = '{word: 8'h00, sig: sig_out, loop: loop_en};
        end else begin
          cur = q.pop_front();
          chk(sig_out == cur.sig, "R4/R7 sig_out at window start", sig_out, cur.sig);
        end
      end
      if (xmt_en) begin
        width++;
        if (ser_clk && !prev_sc) begin
          pulses++;
          bits = {bits[6:0], ser_dat};
        end
      end
      if (!xmt_en && prev_xe) begin
        chk(width == WIN_LEN, "R1 window length", width, WIN_LEN);
        if (cur.loop) begin
          chk(pulses == 0, "R9 no clock in loopback", pulses, 0);
        end else begin
          chk(pulses == WORD_W, "R2 pulse count", pulses, WORD_W);
          chk(bits == cur.word, "R3/R6 serial word", bits, cur.word);
        end
      end
      prev_xe = xmt_en;
      prev_sc = ser_clk;
    end
  end

  task automatic burst(input logic [7:0] w, input logic [1:0] s);
    exp_t e;
    @(negedge clk);
    frm_word = w; frm_sig = s; frm_done = 1'b1;
    e.word = tone_en ? tone_now() : w;
    e.sig = s; e.loop = loop_en;
    q.push_back(e);
    win_exp++;
    last_sig = s;
    ticks_since_done = 0;
    @(negedge clk);
    frm_done = 1'b0;
    chk(xmt_en == 1'b1, "R1 window opens next cycle", xmt_en, 1);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic burst_extra(input logic [7:0] w, input logic [1:0] s,
                             input logic [7:0] w2, input logic [1:0] s2);
    exp_t e;
    @(negedge clk);
    frm_word = w; frm_sig = s; frm_done = 1'b1;
    e.word = w; e.sig = s; e.loop = loop_en;
    q.push_back(e);
    win_exp++;
    last_sig = s;
    ticks_since_done = 0;
    @(negedge clk);
    frm_done = 1'b0;
    repeat (10) @(negedge clk);
    frm_word = w2; frm_sig = s2; frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
    chk(sig_out == s, "R5 sig_out unchanged by late strobe", sig_out, s);
    repeat (GAP) @(negedge clk);
    chk(win_seen == win_exp, "R5 no extra window", win_seen, win_exp);
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    tick_125 = 1'b1;
    if (tone_en && ticks_since_done >= MISS_TICKS) begin
      e.word = tone_now(); e.sig = last_sig; e.loop = loop_en;
      q.push_back(e);
      win_exp++;
    end
    ticks_total++;
    ticks_since_done++;
    @(negedge clk);
    tick_125 = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(xmt_en == 0, "R10 reset xmt_en", xmt_en, 0);
    chk(ser_clk == 0, "R10 reset ser_clk", ser_clk, 0);
    chk(sig_out == 0, "R10 reset sig_out", sig_out, 0);

    // R1 R2 R3 R4: plain voice bursts
    burst(8'hA5, 2'b01);
    burst(8'h3C, 2'b10);
    burst(8'hFF, 2'b11);
    burst(8'h00, 2'b00);
    burst(8'h81, 2'b10);

    // R5: strobe during an open window
    burst_extra(8'h5A, 2'b01, 8'hC3, 2'b10);

    // R8: starved, tone off, ticks open nothing
    for (int i = 0; i < 4; i++) tick();
    chk(win_seen == win_exp, "R8 no self window without tone", win_seen, win_exp);

    // R6: tone replaces the burst word
    tone_en = 1'b1;
    burst(8'h12, 2'b11);
    // R7: self windows after MISS_TICKS silent ticks, crossing tone phases
    for (int i = 0; i < 18; i++) tick();
    chk(win_seen == win_exp, "R7 self window count", win_seen, win_exp);
    burst(8'h44, 2'b01);

    // R9: loopback keeps framing, clock held low
    tone_en = 1'b0;
    loop_en = 1'b1;
    burst(8'h77, 2'b10);
    chk(ser_clk == 0, "R9 ser_clk low in loopback", ser_clk, 0);
    loop_en = 1'b0;
    burst(8'hE7, 2'b01);

    repeat (GAP) @(negedge clk);
    chk(q.size() == 0, "R1 all expected windows seen", q.size(), 0);
    chk(win_seen == win_exp, "R8 window total", win_seen, win_exp);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule